// File: doc/BRIEF.md
# Multi-Destination Pending-EOI Tracker

This block follows end-of-interrupt acknowledgements for a single edge-triggered interrupt line that can be sent to several CPUs at once. When the line is delivered, the tracker records which CPUs received it and which vector each one got. It also keeps a count of acknowledgements still owed. As long as that count is non-zero, a fresh assertion of the line is reported back as coalesced, so the source learns that an earlier instance has not yet been serviced. Working out the destinations and signalling the interrupt are handled outside this block. It only receives the destination mask and the delivery result.

Each cycle the tracker works through its inputs in a fixed order. It handles an acknowledgement first, then a delivery, then a per-CPU restore. A restore compares a CPU's externally reported pending status with the stored bit and corrects any difference.

If an update would drive the count below zero, the tracker discards its state and rebuilds it. A rebuild can also be requested explicitly. During a rebuild the controller visits one CPU per cycle, from CPU 0 upwards. It presents the CPU number on `walk_cpu_o` and takes `walk_hit_i` as the answer to "this CPU is a destination and still has the line's vector pending".

The controller has two states:
- `ST_IDLE` handles events.
- `ST_WALK` performs the rebuild.

The transitions between them are:
- `IDLE→WALK` on a rebuild request or an underflow.
- `WALK→WALK` to advance to the next CPU.
- `WALK→IDLE` after the last CPU, or on a clear.

Top module: `eoi_pend_tracker`

## Requirements
- R1: Reset or `clr_i` sets the count and every bitmap bit to zero and returns the controller to `ST_IDLE`. `clr_i` takes priority over every other input.
- R2: In `ST_IDLE`, a delivery is accepted when the count is zero after that cycle's acknowledgement, and `dlv_taken_o` is high in that cycle. An accepted delivery does three things:
  - it sets the bit of every CPU whose bit in `dlv_dest_i` is set (bit i stands for CPU i);
  - it records `dlv_vec_i` as the vector for each of those CPUs;
  - it loads the count from the two's-complement `dlv_res_i`, where a negative value loads zero.
- R3: A delivery seen while the count is still non-zero after that cycle's acknowledgement is ignored. The bitmap and the count are unchanged and `dlv_taken_o` stays low.
- R4: `coalesced_o` is high exactly when `line_req_i` is high and either the count is non-zero or the controller is in `ST_WALK`.
- R5: An acknowledgement clears CPU `eoi_cpu_i`'s bit and decrements the count only when that bit is set and `eoi_vec_i` equals the vector recorded for that CPU. Otherwise it has no effect.
- R6: When an acknowledgement and a delivery arrive in the same cycle, the acknowledgement is applied first. A delivery can therefore be accepted in the same cycle as the acknowledgement that brings the count to zero.
- R7: A restore for CPU `rsto_cpu_i` acts only when `rsto_pend_i` differs from that CPU's bit, and it is applied after that cycle's acknowledgement and delivery.
  - If `rsto_pend_i` is high, the restore sets the bit, records `line_vec_i` as that CPU's vector and increments the count.
  - If `rsto_pend_i` is low, it clears the bit and decrements the count.
- R8: If a decrement would take the count below zero, that cycle's updates are discarded. The bitmap and the count are zeroed and the controller enters `ST_WALK`.
- R9: A rebuild runs after `rebuild_i` or after an underflow, and lasts NCPU cycles, during which `busy_o` is high.
  - On the step where `walk_cpu_o` is k, the tracker visits CPU k, for k from 0 upwards.
  - When `walk_hit_i` is high on that step, the tracker sets bit k, records `line_vec_i` for CPU k and increments the count.
- R10: While `busy_o` is high, deliveries, acknowledgements and restores are ignored, and `dlv_taken_o` stays low.
- R11: The count saturates at its maximum (15 for a 4-bit count) and never wraps on an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr_i | input | 1 | Synchronous full clear |
| dlv_valid_i | input | 1 | Delivery event |
| dlv_dest_i | input | NCPU | Destination mask of the delivery |
| dlv_vec_i | input | VEC_W | Vector delivered |
| dlv_res_i | input | CNT_W+1 | Signed delivery result (number of CPUs reached) |
| eoi_valid_i | input | 1 | Acknowledgement event |
| eoi_cpu_i | input | CPU_W | CPU sending the acknowledgement |
| eoi_vec_i | input | VEC_W | Vector acknowledged |
| rsto_valid_i | input | 1 | Per-CPU restore event |
| rsto_cpu_i | input | CPU_W | CPU being restored |
| rsto_pend_i | input | 1 | Current pending status of that CPU |
| rebuild_i | input | 1 | Request a full rebuild |
| line_vec_i | input | VEC_W | Vector currently programmed for the line |
| walk_hit_i | input | 1 | Visited CPU is a destination with the vector pending |
| line_req_i | input | 1 | New assertion of the line |
| coalesced_o | output | 1 | New assertion is coalesced |
| dlv_taken_o | output | 1 | Delivery accepted this cycle |
| walk_cpu_o | output | CPU_W | CPU visited by the rebuild |
| busy_o | output | 1 | Rebuild in progress |
| pend_map_o | output | NCPU | Per-CPU pending bitmap |
| pend_cnt_o | output | CNT_W | Outstanding acknowledgement count |

## Verification
The bench uses the default parameters: 8 CPUs, 8-bit vectors and a 4-bit count. With these values a full rebuild takes only eight cycles, so the bench can check every step of the walk, including events presented in the middle of it. A 4-bit count means a single delivery result of 15 followed by one restore reaches the saturation limit. The signed 5-bit result field lets the bench present a negative result and watch it load zero. That leaves set bits alongside a zero count, which the bench then uses to force an underflow and an automatic rebuild.

// File: rtl/pet_pkg.sv
`timescale 1ns/1ps
package pet_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } pet_state_e;
endpackage

// File: rtl/pet_event.sv
`timescale 1ns/1ps
// Per-cycle event update: acknowledgement, then delivery, then restore.
module pet_event #(
    parameter int NCPU  = 8,
    parameter int VEC_W = 8,
    parameter int CNT_W = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic [NCPU-1:0]            map_q,
    input  logic [CNT_W-1:0]           cnt_q,
    input  logic [NCPU-1:0][VEC_W-1:0] vec_q,
    input  logic                       dlv_valid,
    input  logic [NCPU-1:0]            dlv_dest,
    input  logic [VEC_W-1:0]           dlv_vec,
    input  logic [CNT_W:0]             dlv_res,
    input  logic                       eoi_valid,
    input  logic [CPU_W-1:0]           eoi_cpu,
    input  logic [VEC_W-1:0]           eoi_vec,
    input  logic                       rsto_valid,
    input  logic [CPU_W-1:0]           rsto_cpu,
    input  logic                       rsto_pend,
    input  logic [VEC_W-1:0]           line_vec,
    output logic [NCPU-1:0]            map_d,
    output logic [CNT_W-1:0]           cnt_d,
    output logic [NCPU-1:0][VEC_W-1:0] vec_d,
    output logic                       taken,
    output logic                       underflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        map_d     = map_q;
        cnt_d     = cnt_q;
        vec_d     = vec_q;
        taken     = 1'b0;
        underflow = 1'b0;

        // acknowledgement first
        if (eoi_valid && map_d[eoi_cpu] && (vec_d[eoi_cpu] == eoi_vec)) begin
            map_d[eoi_cpu] = 1'b0;
            if (cnt_d == '0) underflow = 1'b1;
            else             cnt_d = cnt_d - 1'b1;
        end

        // delivery sees the post-acknowledgement count
        if (dlv_valid && (cnt_d == '0)) begin
            taken = 1'b1;
            for (int i = 0; i < NCPU; i++) begin
                if (dlv_dest[i]) begin
                    map_d[i] = 1'b1;
                    vec_d[i] = dlv_vec;
                end
            end
            cnt_d = dlv_res[CNT_W] ? '0 : dlv_res[CNT_W-1:0];
        end

        // per-CPU restore last
        if (rsto_valid && (rsto_pend != map_d[rsto_cpu])) begin
            if (rsto_pend) begin
                map_d[rsto_cpu] = 1'b1;
                vec_d[rsto_cpu] = line_vec;
                if (cnt_d != CNT_MAX) cnt_d = cnt_d + 1'b1;
            end else begin
                map_d[rsto_cpu] = 1'b0;
                if (cnt_d == '0) underflow = 1'b1;
                else             cnt_d = cnt_d - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pet_walk_fsm.sv
`timescale 1ns/1ps
// Rebuild controller: idles, or walks one CPU per cycle.
module pet_walk_fsm
    import pet_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    output pet_state_e       state,
    output logic [CPU_W-1:0] idx,
    output logic             busy,
    output logic             step
);
    localparam logic [CPU_W-1:0] LAST = CPU_W'(NCPU - 1);

    pet_state_e       state_nxt;
    logic [CPU_W-1:0] idx_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_IDLE: begin
                if (!clr && start) begin
                    state_nxt = ST_WALK;   // IDLE->WALK
                    idx_nxt   = '0;
                end
            end
            ST_WALK: begin
                if (clr || idx == LAST) begin
                    state_nxt = ST_IDLE;   // WALK->IDLE
                    idx_nxt   = '0;
                end else begin
                    idx_nxt   = idx + 1'b1; // WALK->WALK
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == ST_WALK);
        step = busy && !clr;
    end
endmodule

// File: rtl/eoi_pend_tracker.sv
`timescale 1ns/1ps
module eoi_pend_tracker
    import pet_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int VEC_W = 8,
    parameter int CNT_W = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              dlv_valid_i,
    input  logic [NCPU-1:0]   dlv_dest_i,
    input  logic [VEC_W-1:0]  dlv_vec_i,
    input  logic [CNT_W:0]    dlv_res_i,
    input  logic              eoi_valid_i,
    input  logic [CPU_W-1:0]  eoi_cpu_i,
    input  logic [VEC_W-1:0]  eoi_vec_i,
    input  logic              rsto_valid_i,
    input  logic [CPU_W-1:0]  rsto_cpu_i,
    input  logic              rsto_pend_i,
    input  logic              rebuild_i,
    input  logic [VEC_W-1:0]  line_vec_i,
    input  logic              walk_hit_i,
    input  logic              line_req_i,
    output logic              coalesced_o,
    output logic              dlv_taken_o,
    output logic [CPU_W-1:0]  walk_cpu_o,
    output logic              busy_o,
    output logic [NCPU-1:0]   pend_map_o,
    output logic [CNT_W-1:0]  pend_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NCPU-1:0]            map_q, map_d;
    logic [CNT_W-1:0]           cnt_q, cnt_d;
    logic [NCPU-1:0][VEC_W-1:0] vec_q, vec_d;
    logic                       ev_taken, ev_uf;
    logic                       ev_ok, start;
    logic                       busy, step;
    logic [CPU_W-1:0]           idx;
    pet_state_e                 state;

    pet_event #(.NCPU(NCPU), .VEC_W(VEC_W), .CNT_W(CNT_W), .CPU_W(CPU_W)) u_event (
        .map_q      (map_q),
        .cnt_q      (cnt_q),
        .vec_q      (vec_q),
        .dlv_valid  (dlv_valid_i),
        .dlv_dest   (dlv_dest_i),
        .dlv_vec    (dlv_vec_i),
        .dlv_res    (dlv_res_i),
        .eoi_valid  (eoi_valid_i),
        .eoi_cpu    (eoi_cpu_i),
        .eoi_vec    (eoi_vec_i),
        .rsto_valid (rsto_valid_i),
        .rsto_cpu   (rsto_cpu_i),
        .rsto_pend  (rsto_pend_i),
        .line_vec   (line_vec_i),
        .map_d      (map_d),
        .cnt_d      (cnt_d),
        .vec_d      (vec_d),
        .taken      (ev_taken),
        .underflow  (ev_uf)
    );

    // events count only in IDLE with no clear and no explicit rebuild
    always_comb begin
        ev_ok = (state == ST_IDLE) && !clr_i && !rebuild_i;
        start = rebuild_i || (ev_ok && ev_uf);
    end

    pet_walk_fsm #(.NCPU(NCPU), .CPU_W(CPU_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .start (start),
        .state (state),
        .idx   (idx),
        .busy  (busy),
        .step  (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
            cnt_q <= '0;
            vec_q <= '0;
        end else if (clr_i) begin
            map_q <= '0;
            cnt_q <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                map_q <= '0;
                cnt_q <= '0;
            end else begin
                map_q <= map_d;
                cnt_q <= cnt_d;
                vec_q <= vec_d;
            end
        end else if (step && walk_hit_i) begin
            map_q[idx] <= 1'b1;
            vec_q[idx] <= line_vec_i;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        coalesced_o = line_req_i && (busy || (cnt_q != '0));
        dlv_taken_o = ev_ok && ev_taken && !ev_uf;
        walk_cpu_o  = idx;
        busy_o      = busy;
        pend_map_o  = map_q;
        pend_cnt_o  = cnt_q;
    end
endmodule

// File: rtl/pet_chk.sv
`timescale 1ns/1ps
module pet_chk #(
    parameter int NCPU  = 8,
    parameter int VEC_W = 8,
    parameter int CNT_W = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             dlv_valid_i,
    input logic             eoi_valid_i,
    input logic [CPU_W-1:0] eoi_cpu_i,
    input logic             rsto_valid_i,
    input logic             rebuild_i,
    input logic             line_req_i,
    input logic             coalesced_o,
    input logic             dlv_taken_o,
    input logic [CPU_W-1:0] walk_cpu_o,
    input logic             busy_o,
    input logic [NCPU-1:0]  pend_map_o,
    input logic [CNT_W-1:0] pend_cnt_o
);
    // R1
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pend_cnt_o == '0) && (pend_map_o == '0) && !busy_o);

    // R3
    busy_count_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt_o > CNT_W'(1)) |-> !dlv_taken_o);

    // R4
    walk_coalesces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && line_req_i) |-> coalesced_o);

    // R5
    stray_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid_i && !busy_o && !pend_map_o[eoi_cpu_i] && !dlv_valid_i &&
         !rsto_valid_i && !clr_i && !rebuild_i)
        |=> (pend_map_o == $past(pend_map_o)));

    // R9
    walk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !clr_i && (walk_cpu_o != CPU_W'(NCPU - 1)))
        |=> busy_o && (walk_cpu_o == $past(walk_cpu_o) + 1'b1));

    // R10
    walk_no_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !dlv_taken_o);
endmodule

bind eoi_pend_tracker pet_chk #(
    .NCPU(NCPU), .VEC_W(VEC_W), .CNT_W(CNT_W), .CPU_W(CPU_W)
) u_chk (.*);

// File: tb/eoi_pend_tracker_test.sv
`timescale 1ns/1ps
module eoi_pend_tracker_test;
    localparam int NCPU = 8, VEC_W = 8, CNT_W = 4, CPU_W = 3;

    typedef struct packed {
        logic       dv;
        logic [7:0] dest;
        logic [7:0] dvec;
        logic [4:0] dres;
        logic       ev;
        logic [2:0] ecpu;
        logic [7:0] evec;
        logic       rv;
        logic [2:0] rcpu;
        logic       rp;
        logic       lreq;
        logic       x_tk;
        logic       x_co;
        logic [7:0] x_map;
        logic [3:0] x_cnt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1,8'h0F,8'h41,5'd4, 1'b0,3'd0,8'h00, 1'b0,3'd0,1'b0, 1'b1, 1'b1,1'b0,8'h0F,4'd4, 4'd2}, // R2
        '{1'b0,8'h00,8'h00,5'd0, 1'b0,3'd0,8'h00, 1'b0,3'd0,1'b0, 1'b1, 1'b0,1'b1,8'h0F,4'd4, 4'd4}, // R4
        '{1'b1,8'hF0,8'h55,5'd4, 1'b0,3'd0,8'h00, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h0F,4'd4, 4'd3}, // R3
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd1,8'h42, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h0F,4'd4, 4'd5}, // R5 vector mismatch
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd5,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h0F,4'd4, 4'd5}, // R5 bit clear
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd1,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h0D,4'd3, 4'd5},
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd0,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h0C,4'd2, 4'd5},
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd2,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h08,4'd1, 4'd5},
        '{1'b1,8'h30,8'h55,5'd2, 1'b1,3'd3,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b1,1'b0,8'h30,4'd2, 4'd6}, // R6
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd4,8'h41, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h30,4'd2, 4'd5}, // R5 stale vector
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd4,8'h55, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h20,4'd1, 4'd5},
        '{1'b0,8'h00,8'h00,5'd0, 1'b1,3'd5,8'h55, 1'b0,3'd0,1'b0, 1'b0, 1'b0,1'b0,8'h00,4'd0, 4'd5},
        '{1'b1,8'h03,8'h60,5'h1F,1'b0,3'd0,8'h00, 1'b0,3'd0,1'b0, 1'b0, 1'b1,1'b0,8'h03,4'd0, 4'd2}, // R2 negative
        '{1'b0,8'h00,8'h00,5'd0, 1'b0,3'd0,8'h00, 1'b0,3'd0,1'b0, 1'b1, 1'b0,1'b0,8'h03,4'd0, 4'd4},
        '{1'b0,8'h00,8'h00,5'd0, 1'b0,3'd0,8'h00, 1'b1,3'd0,1'b1, 1'b0, 1'b0,1'b0,8'h03,4'd0, 4'd7}, // R7 equal
        '{1'b0,8'h00,8'h00,5'd0, 1'b0,3'd0,8'h00, 1'b1,3'd2,1'b1, 1'b0, 1'b0,1'b0,8'h07,4'd1, 4'd7},
        '{1'b0,8'h00,8'h00,5'd0, 1'b0,3'd0,8'h00, 1'b1,3'd2,1'b0, 1'b0, 1'b0,1'b0,8'h03,4'd0, 4'd7}
    };

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic dv = 1'b0, ev = 1'b0, rv = 1'b0, rp = 1'b0, rebuild = 1'b0, lreq = 1'b0;
    logic [7:0] dest = '0, dvec = '0, evec = '0, lvec = 8'h30, hit_mask = '0;
    logic [4:0] dres = '0;
    logic [2:0] ecpu = '0, rcpu = '0;
    logic walk_hit, coal, taken, busy;
    logic [2:0] wcpu;
    logic [7:0] map;
    logic [3:0] cnt;
    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;
    assign walk_hit = hit_mask[wcpu];

    eoi_pend_tracker uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .dlv_valid_i(dv), .dlv_dest_i(dest), .dlv_vec_i(dvec), .dlv_res_i(dres),
        .eoi_valid_i(ev), .eoi_cpu_i(ecpu), .eoi_vec_i(evec),
        .rsto_valid_i(rv), .rsto_cpu_i(rcpu), .rsto_pend_i(rp),
        .rebuild_i(rebuild), .line_vec_i(lvec), .walk_hit_i(walk_hit),
        .line_req_i(lreq), .coalesced_o(coal), .dlv_taken_o(taken),
        .walk_cpu_o(wcpu), .busy_o(busy), .pend_map_o(map), .pend_cnt_o(cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        clr = 0; dv = 0; ev = 0; rv = 0; rebuild = 0; lreq = 0;
    endtask

    task automatic state_chk(input string req, input int xmap, input int xcnt, input int xbusy);
        chk(req, "map", int'(map), xmap);
        chk(req, "count", int'(cnt), xcnt);
        chk(req, "busy", int'(busy), xbusy);
    endtask

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        state_chk("R1", 0, 0, 0);
        lreq = 1; #2; chk("R4", "coalesced after reset", int'(coal), 0); lreq = 0;
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            dv = TBL[i].dv; dest = TBL[i].dest; dvec = TBL[i].dvec; dres = TBL[i].dres;
            ev = TBL[i].ev; ecpu = TBL[i].ecpu; evec = TBL[i].evec;
            rv = TBL[i].rv; rcpu = TBL[i].rcpu; rp = TBL[i].rp; lreq = TBL[i].lreq;
            #2;
            chk($sformatf("R%0d", TBL[i].req), "taken", int'(taken), int'(TBL[i].x_tk));
            chk($sformatf("R%0d", TBL[i].req), "coalesced", int'(coal), int'(TBL[i].x_co));
            @(negedge clk);
            idle_in();
            state_chk($sformatf("R%0d", TBL[i].req), int'(TBL[i].x_map), int'(TBL[i].x_cnt), 0);
        end

        // R8 underflow: bit0 set with vector 60, count already zero
        hit_mask = 8'hA5; lvec = 8'h30;
        ev = 1; ecpu = 3'd0; evec = 8'h60;
        @(negedge clk);
        idle_in();
        state_chk("R8", 0, 0, 1);
        for (int k = 0; k < NCPU; k++) begin
            dv = (k == 2); dest = 8'hFF; dres = 5'd1; lreq = (k == 2);
            #2;
            chk("R9", "walk cpu", int'(wcpu), k);
            if (k == 2) begin
                chk("R10", "taken during walk", int'(taken), 0);
                chk("R4", "coalesced during walk", int'(coal), 1);
            end
            @(negedge clk);
            idle_in();
        end
        state_chk("R9", 8'hA5, 4, 0);

        // R9 rebuilt vector is the line vector
        ev = 1; ecpu = 3'd7; evec = 8'h30;
        @(negedge clk); idle_in();
        state_chk("R9", 8'h25, 3, 0);

        // R9 explicit rebuild
        hit_mask = 8'h01; rebuild = 1;
        @(negedge clk); idle_in();
        state_chk("R9", 0, 0, 1);
        repeat (NCPU) @(negedge clk);
        state_chk("R9", 8'h01, 1, 0);

        // R1 clear in the middle of a walk
        hit_mask = 8'hFF; rebuild = 1;
        @(negedge clk); idle_in();
        repeat (3) @(negedge clk);
        clr = 1;
        @(negedge clk); idle_in();
        state_chk("R1", 0, 0, 0);

        // R11 saturation
        dv = 1; dest = 8'h7F; dvec = 8'h70; dres = 5'd15;
        @(negedge clk); idle_in();
        state_chk("R11", 8'h7F, 15, 0);
        rv = 1; rcpu = 3'd7; rp = 1;
        @(negedge clk); idle_in();
        state_chk("R11", 8'hFF, 15, 0);

        // R1 clear from idle
        clr = 1;
        @(negedge clk); idle_in();
        state_chk("R1", 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule